// File: doc/BRIEF.md
# Synchronization-Count Thread Enabler

This block keeps the books for threads that are waiting on their inputs. A thread is created against a frame slot with an instruction pointer and a count of the inputs it still needs. Every post-store into that frame lowers the count by one. When the count reaches zero the thread goes into an in-order ready queue. As soon as a register context is free, the block takes the thread at the head of the queue, gives it the next context in ring order and announces it on the enabled-thread output. The frame slot is then free for a new thread.

Register contexts are taken and returned strictly in ring order. Each context carries a phase: free, preload, execute or post-store. A fork-to-execute request moves a context from preload to execute, and a fork-to-post-store request moves it from execute to post-store. In both cases the new phase appears a fixed number of cycles after the request. A release returns the oldest held context, but only once that context has reached post-store. A request that breaks these rules sets a sticky error flag and has no other effect.

Top module: `thread_enabler`

## Requirements
- R1: A create on an idle frame records the instruction pointer and input count. When the thread is later enabled, `en_frame` and `en_ip` carry that frame and that pointer.
- R2: Each valid decrement lowers the target thread's count by one. A thread created with count N is enabled only after its N-th decrement, and never before it.
- R3: A create with count zero enables the thread at once. `en_valid` pulses for one cycle, two clock edges after the create is sampled.
- R4: Contexts are handed out in ring order 0, 1, …, NCTX-1, 0, and `en_ctx` reports the context given.
- R5: When every context is held, enabled threads wait in the ready queue in the order they were enabled. The head of the queue is dispatched one edge after a release frees a context.
- R6: Context phases use the 2-bit encoding free=0, preload=1, execute=2, post-store=3, packed into `ctx_phase[2*c+1:2*c]`. A dispatched context shows preload. An accepted fork-to-execute (from preload) or fork-to-post-store (from execute) changes the phase exactly FORK_LAT (default 4) edges after the request is sampled.
- R7: A release frees the oldest held context when its phase is post-store, and that context returns to free.
- R8: A decrement aimed at an idle frame, at an out-of-range frame, or at a frame whose count is already zero sets the sticky `err` flag and changes no count. `err` stays set until reset.
- R9: A create and a decrement that arrive in the same cycle for different frames are both applied. If both enable a thread, the decremented thread is queued first.
- R10: A create on a frame that is not idle, a fork aimed at a context in the wrong phase or with a fork already pending, and a release while the oldest context is not in post-store all set `err` and are otherwise ignored.
- R11: After reset `err` is 0, `en_valid` is 0 and every context is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crt_valid | input | 1 | Create request |
| crt_frame | input | FID_W | Frame slot of the new thread |
| crt_ip | input | IP_W | Instruction pointer of the new thread |
| crt_count | input | CNT_W | Number of inputs the thread needs |
| dec_valid | input | 1 | Post-store decrement request |
| dec_frame | input | FID_W | Frame that received the post-store |
| fork_ep_valid | input | 1 | Move a context from preload to execute |
| fork_sp_valid | input | 1 | Move a context from execute to post-store (fork_ep_valid takes precedence) |
| fork_ctx | input | CTX_W | Context targeted by the fork |
| rel_valid | input | 1 | Release the oldest held context |
| en_valid | output | 1 | One-cycle pulse: a thread was dispatched |
| en_frame | output | FID_W | Frame of the dispatched thread |
| en_ip | output | IP_W | Instruction pointer of the dispatched thread |
| en_ctx | output | CTX_W | Context given to the dispatched thread |
| ctx_phase | output | 2*NCTX | Packed phase of every context |
| err | output | 1 | Sticky protocol error flag |

## Verification
The assertions assume that the ready queue never has to take more entries than there are frames. Because a frame slot stays busy until its thread is dispatched, the queue depth equals the frame count, so this holds for any legal or illegal request pattern. The stimulus also never raises both fork requests in the same cycle. The ring-order and phase-step properties rely on contexts moving only through the block's own dispatch, fork and release paths. The error scenarios are each run right after a fresh reset, so that the sticky flag reports one kind of misuse at a time.

// File: rtl/te_pkg.sv
package te_pkg;
  typedef enum logic [1:0] {
    PH_FREE = 2'd0,
    PH_PRE  = 2'd1,
    PH_EXE  = 2'd2,
    PH_POST = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_WAIT   = 2'd1,
    FS_QUEUED = 2'd2
  } fstate_e;
endpackage

// File: rtl/te_frame_table.sv
module te_frame_table
  import te_pkg::*;
#(
  parameter int NFR   = 8,
  parameter int IP_W  = 16,
  parameter int CNT_W = 4,
  parameter int FID_W = $clog2(NFR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crt_valid,
  input  logic [FID_W-1:0] crt_frame,
  input  logic [IP_W-1:0]  crt_ip,
  input  logic [CNT_W-1:0] crt_count,
  input  logic             dec_valid,
  input  logic [FID_W-1:0] dec_frame,
  input  logic             clr_valid,
  input  logic [FID_W-1:0] clr_frame,
  output logic             dec_push,
  output logic             crt_push,
  output logic             dec_bad,
  output logic             crt_bad,
  output logic [IP_W-1:0]  clr_ip
);
  fstate_e          st  [NFR];
  logic [CNT_W-1:0] cnt [NFR];
  logic [IP_W-1:0]  ipm [NFR];
  logic             crt_ok, dec_ok;

  function automatic logic known(input logic [FID_W-1:0] f);
    return int'(f) < NFR;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  always_comb begin
    crt_ok   = crt_valid && known(crt_frame) && (st[crt_frame] == FS_IDLE);
    dec_ok   = dec_valid && known(dec_frame) && (st[dec_frame] == FS_WAIT);
    crt_bad  = crt_valid && !crt_ok;
    dec_bad  = dec_valid && !dec_ok;
    crt_push = crt_ok && (crt_count == '0);
    dec_push = dec_ok && (cnt[dec_frame] == CNT_W'(1));
    clr_ip   = ipm[clr_frame];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFR; i++) begin
        st[i]  <= FS_IDLE;
        cnt[i] <= '0;
        ipm[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NFR; i++) begin
        if (crt_ok && crt_frame == FID_W'(i)) begin
          st[i]  <= (crt_count == '0) ? FS_QUEUED : FS_WAIT;
          cnt[i] <= crt_count;
          ipm[i] <= crt_ip;
        end
        if (dec_ok && dec_frame == FID_W'(i)) begin
          cnt[i] <= step_down(cnt[i]);
          if (cnt[i] == CNT_W'(1)) st[i] <= FS_QUEUED;
        end
        if (clr_valid && clr_frame == FID_W'(i)) st[i] <= FS_IDLE;
      end
    end
  end
endmodule

// File: rtl/te_ready_fifo.sv
module te_ready_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_a,
  input  logic [W-1:0] din_a,
  input  logic         push_b,
  input  logic [W-1:0] din_b,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr, rd;
  logic [CW-1:0] level;
  int            n_in;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  always_comb begin
    n_in  = int'(push_a) + int'(push_b);
    empty = (level == '0);
    head  = mem[rd];
    ovf   = (int'(level) + n_in - int'(pop)) > DEPTH;
  end

  always_ff @(posedge clk) begin
    if (!ovf) begin
      if (push_a) mem[wr] <= din_a;
      if (push_b) mem[push_a ? adv(wr, 1) : wr] <= din_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr    <= '0;
      rd    <= '0;
      level <= '0;
    end else begin
      if (!ovf) begin
        wr    <= adv(wr, n_in);
        level <= CW'(int'(level) + n_in - int'(pop));
      end else begin
        level <= CW'(int'(level) - int'(pop));
      end
      if (pop) rd <= adv(rd, 1);
    end
  end
endmodule

// File: rtl/te_ctx_pool.sv
module te_ctx_pool
  import te_pkg::*;
#(
  parameter int NCTX     = 4,
  parameter int FORK_LAT = 4,
  parameter int CTX_W    = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              rel_valid,
  input  logic              fork_ep,
  input  logic              fork_sp,
  input  logic [CTX_W-1:0]  fork_ctx,
  output logic [CTX_W-1:0]  alloc_ctx,
  output logic              has_free,
  output logic              rel_bad,
  output logic              fork_bad,
  output logic [2*NCTX-1:0] phases
);
  localparam int UW = $clog2(NCTX + 1);
  localparam int TW = $clog2(FORK_LAT + 1);

  phase_e        ph   [NCTX];
  phase_e        tgt  [NCTX];
  logic          pend [NCTX];
  logic [TW-1:0] tmr  [NCTX];
  logic [CTX_W-1:0] tail, head;
  logic [UW-1:0] used;
  logic          rel_ok, fork_req, fork_ok;
  phase_e        need;

  function automatic logic [CTX_W-1:0] ring_next(input logic [CTX_W-1:0] p);
    return (int'(p) == NCTX - 1) ? '0 : p + CTX_W'(1);
  endfunction

  always_comb begin
    alloc_ctx = tail;
    has_free  = (int'(used) != NCTX);
    rel_ok    = rel_valid && (ph[head] == PH_POST) && !pend[head];
    rel_bad   = rel_valid && !rel_ok;
    fork_req  = fork_ep || fork_sp;
    need      = fork_ep ? PH_PRE : PH_EXE;
    fork_ok   = fork_req && (int'(fork_ctx) < NCTX) &&
                (ph[fork_ctx] == need) && !pend[fork_ctx];
    fork_bad  = fork_req && !fork_ok;
    for (int i = 0; i < NCTX; i++) phases[2*i +: 2] = ph[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail <= '0;
      head <= '0;
      used <= '0;
      for (int i = 0; i < NCTX; i++) begin
        ph[i]   <= PH_FREE;
        tgt[i]  <= PH_FREE;
        pend[i] <= 1'b0;
        tmr[i]  <= '0;
      end
    end else begin
      if (alloc) tail <= ring_next(tail);
      if (rel_ok) head <= ring_next(head);
      used <= UW'(int'(used) + int'(alloc) - int'(rel_ok));
      for (int i = 0; i < NCTX; i++) begin
        if (alloc && tail == CTX_W'(i)) ph[i] <= PH_PRE;
        if (rel_ok && head == CTX_W'(i)) ph[i] <= PH_FREE;
        if (fork_ok && fork_ctx == CTX_W'(i)) begin
          pend[i] <= 1'b1;
          tgt[i]  <= fork_ep ? PH_EXE : PH_POST;
          tmr[i]  <= TW'(FORK_LAT - 1);
        end else if (pend[i]) begin
          if (tmr[i] == '0) begin
            ph[i]   <= tgt[i];
            pend[i] <= 1'b0;
          end else begin
            tmr[i] <= tmr[i] - TW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/thread_enabler.sv
module thread_enabler #(
  parameter int NFR      = 8,
  parameter int IP_W     = 16,
  parameter int CNT_W    = 4,
  parameter int NCTX     = 4,
  parameter int FORK_LAT = 4,
  parameter int FID_W    = $clog2(NFR),
  parameter int CTX_W    = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crt_valid,
  input  logic [FID_W-1:0]  crt_frame,
  input  logic [IP_W-1:0]   crt_ip,
  input  logic [CNT_W-1:0]  crt_count,
  input  logic              dec_valid,
  input  logic [FID_W-1:0]  dec_frame,
  input  logic              fork_ep_valid,
  input  logic              fork_sp_valid,
  input  logic [CTX_W-1:0]  fork_ctx,
  input  logic              rel_valid,
  output logic              en_valid,
  output logic [FID_W-1:0]  en_frame,
  output logic [IP_W-1:0]   en_ip,
  output logic [CTX_W-1:0]  en_ctx,
  output logic [2*NCTX-1:0] ctx_phase,
  output logic              err
);
  logic             dec_push_w, crt_push_w, dec_bad_w, crt_bad_w;
  logic             rel_bad_w, fork_bad_w, ovf_w;
  logic             q_empty_w, has_free_w, dispatch_w;
  logic [FID_W-1:0] q_head_w;
  logic [IP_W-1:0]  head_ip_w;
  logic [CTX_W-1:0] alloc_ctx_w;

  assign dispatch_w = !q_empty_w && has_free_w;

  te_frame_table #(.NFR(NFR), .IP_W(IP_W), .CNT_W(CNT_W), .FID_W(FID_W)) table_i (
    .clk, .rst_n,
    .crt_valid, .crt_frame, .crt_ip, .crt_count,
    .dec_valid, .dec_frame,
    .clr_valid (dispatch_w),
    .clr_frame (q_head_w),
    .dec_push  (dec_push_w),
    .crt_push  (crt_push_w),
    .dec_bad   (dec_bad_w),
    .crt_bad   (crt_bad_w),
    .clr_ip    (head_ip_w)
  );

  te_ready_fifo #(.DEPTH(NFR), .W(FID_W)) ready_i (
    .clk, .rst_n,
    .push_a (dec_push_w),
    .din_a  (dec_frame),
    .push_b (crt_push_w),
    .din_b  (crt_frame),
    .pop    (dispatch_w),
    .head   (q_head_w),
    .empty  (q_empty_w),
    .ovf    (ovf_w)
  );

  te_ctx_pool #(.NCTX(NCTX), .FORK_LAT(FORK_LAT), .CTX_W(CTX_W)) pool_i (
    .clk, .rst_n,
    .alloc     (dispatch_w),
    .rel_valid,
    .fork_ep   (fork_ep_valid),
    .fork_sp   (fork_sp_valid),
    .fork_ctx,
    .alloc_ctx (alloc_ctx_w),
    .has_free  (has_free_w),
    .rel_bad   (rel_bad_w),
    .fork_bad  (fork_bad_w),
    .phases    (ctx_phase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_valid <= 1'b0;
      en_frame <= '0;
      en_ip    <= '0;
      en_ctx   <= '0;
      err      <= 1'b0;
    end else begin
      en_valid <= dispatch_w;
      if (dispatch_w) begin
        en_frame <= q_head_w;
        en_ip    <= head_ip_w;
        en_ctx   <= alloc_ctx_w;
      end
      err <= err | dec_bad_w | crt_bad_w | rel_bad_w | fork_bad_w | ovf_w;
    end
  end
endmodule

// File: rtl/te_checker.sv
module te_checker #(
  parameter int NCTX  = 4,
  parameter int CTX_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_valid,
  input logic [CTX_W-1:0]  en_ctx,
  input logic [2*NCTX-1:0] ctx_phase,
  input logic              err,
  input logic              dec_bad,
  input logic              fifo_ovf
);
  logic [CTX_W-1:0] exp_ctx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_ctx <= '0;
    else if (en_valid) exp_ctx <= (int'(exp_ctx) == NCTX - 1) ? '0 : exp_ctx + CTX_W'(1);
  end

  // R4
  ctx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_valid |-> en_ctx == exp_ctx);

  // R6
  pre_on_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_valid |-> ctx_phase[{en_ctx, 1'b0} +: 2] == 2'd1);

  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_ph
      // R6
      phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctx_phase[2*c +: 2]) |->
          ctx_phase[2*c +: 2] == 2'($past(ctx_phase[2*c +: 2]) + 2'd1));
    end
  endgenerate

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8
  bad_dec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bad |=> err);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_ovf);
endmodule

bind thread_enabler te_checker #(.NCTX(NCTX), .CTX_W(CTX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_valid  (en_valid),
  .en_ctx    (en_ctx),
  .ctx_phase (ctx_phase),
  .err       (err),
  .dec_bad   (dec_bad_w),
  .fifo_ovf  (ovf_w)
);

// File: tb/thread_enabler_tb_top.sv
`timescale 1ns/1ps
module thread_enabler_tb_top;
  localparam int NFR = 8, IP_W = 16, CNT_W = 4, NCTX = 4, LAT = 4;
  localparam int FID_W = $clog2(NFR), CTX_W = $clog2(NCTX);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crt_valid = 0, dec_valid = 0, fork_ep_valid = 0, fork_sp_valid = 0, rel_valid = 0;
  logic [FID_W-1:0] crt_frame = '0, dec_frame = '0;
  logic [IP_W-1:0]  crt_ip = '0;
  logic [CNT_W-1:0] crt_count = '0;
  logic [CTX_W-1:0] fork_ctx = '0;
  logic              en_valid, err;
  logic [FID_W-1:0]  en_frame;
  logic [IP_W-1:0]   en_ip;
  logic [CTX_W-1:0]  en_ctx;
  logic [2*NCTX-1:0] ctx_phase;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  thread_enabler dut_i (
    .clk, .rst_n, .crt_valid, .crt_frame, .crt_ip, .crt_count,
    .dec_valid, .dec_frame, .fork_ep_valid, .fork_sp_valid, .fork_ctx,
    .rel_valid, .en_valid, .en_frame, .en_ip, .en_ctx, .ctx_phase, .err
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ph(input int c);
    return ctx_phase[2*c +: 2];
  endfunction

  task automatic expect_en(input string req, input int fr, input int ip, input int cx);
    check(en_valid == 1'b1, req, "en_valid", en_valid, 1);
    check(en_frame == FID_W'(fr), req, "en_frame", en_frame, fr);
    check(en_ip == IP_W'(ip), req, "en_ip", en_ip, ip);
    check(en_ctx == CTX_W'(cx), req, "en_ctx", en_ctx, cx);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic create(input int fr, input int ip, input int c);
    crt_valid = 1; crt_frame = FID_W'(fr); crt_ip = IP_W'(ip); crt_count = CNT_W'(c);
  endtask

  task automatic post(input int fr);
    dec_valid = 1; dec_frame = FID_W'(fr);
  endtask

  task automatic idle_in();
    crt_valid = 0; dec_valid = 0; fork_ep_valid = 0; fork_sp_valid = 0; rel_valid = 0;
  endtask

  task automatic t_reset_state();
    check(err == 1'b0, "R11", "err", err, 0);
    check(en_valid == 1'b0, "R11", "en_valid", en_valid, 0);
    check(ctx_phase == '0, "R11", "ctx_phase", ctx_phase, 0);
  endtask

  task automatic t_zero_count();
    create(1, 'h1111, 0); tick(); idle_in();
    check(en_valid == 1'b0, "R3", "en_valid early", en_valid, 0);
    tick();
    expect_en("R3", 1, 'h1111, 0);          // first context is 0 (R4)
    check(ph(0) == 2'd1, "R6", "ctx0 preload", ph(0), 1);
    tick();
    check(en_valid == 1'b0, "R3", "single pulse", en_valid, 0);
  endtask

  task automatic t_count_down();
    create(2, 'h2222, 3); tick(); idle_in();
    post(2); tick(); idle_in();
    post(2); tick(); idle_in();
    repeat (3) begin
      tick();
      check(en_valid == 1'b0, "R2", "enabled before last input", en_valid, 0);
    end
    post(2); tick(); idle_in();
    check(en_valid == 1'b0, "R2", "en_valid at last dec", en_valid, 0);
    tick();
    expect_en("R1", 2, 'h2222, 1);
  endtask

  task automatic t_same_cycle();
    create(3, 'h3333, 1); tick(); idle_in();
    create(4, 'h4444, 0); post(3); tick(); idle_in();
    tick();
    expect_en("R9", 3, 'h3333, 2);
    tick();
    expect_en("R9", 4, 'h4444, 3);
  endtask

  task automatic t_full_and_phases();
    create(5, 'h5555, 0); tick(); idle_in();
    repeat (4) begin
      tick();
      check(en_valid == 1'b0, "R5", "dispatch while full", en_valid, 0);
    end
    fork_ep_valid = 1; fork_ctx = 0; tick(); idle_in();
    check(ph(0) == 2'd1, "R6", "phase after fork edge", ph(0), 1);
    for (int i = 1; i < LAT; i++) begin
      tick();
      check(ph(0) == 2'd1, "R6", "phase during fork", ph(0), 1);
    end
    tick();
    check(ph(0) == 2'd2, "R6", "execute after fork", ph(0), 2);
    fork_sp_valid = 1; fork_ctx = 0; tick(); idle_in();
    for (int i = 1; i < LAT; i++) begin
      tick();
      check(ph(0) == 2'd2, "R6", "phase during fork", ph(0), 2);
    end
    tick();
    check(ph(0) == 2'd3, "R6", "post-store after fork", ph(0), 3);
    rel_valid = 1; tick(); idle_in();
    check(ph(0) == 2'd0, "R7", "released ctx free", ph(0), 0);
    check(en_valid == 1'b0, "R5", "en_valid at release", en_valid, 0);
    tick();
    expect_en("R5", 5, 'h5555, 0);          // ring wraps to 0 (R4)
    check(err == 1'b0, "R7", "no error on legal flow", err, 0);
  endtask

  task automatic t_bad_release();
    rel_valid = 1; tick(); idle_in();
    check(err == 1'b1, "R10", "err on early release", err, 1);
    check(ph(1) == 2'd1, "R10", "ctx1 unchanged", ph(1), 1);
  endtask

  task automatic t_bad_dec();
    create(6, 'h6666, 2); tick(); idle_in();
    post(7); tick(); idle_in();
    check(err == 1'b1, "R8", "err on idle-frame dec", err, 1);
    post(6); tick(); idle_in();
    tick(); tick();
    check(en_valid == 1'b0, "R8", "count untouched", en_valid, 0);
    post(6); tick(); idle_in();
    tick();
    expect_en("R8", 6, 'h6666, 0);
    check(err == 1'b1, "R8", "err sticky", err, 1);
    post(6); tick(); idle_in();           // frame is idle again: count already used up
    tick(); tick();
    check(en_valid == 1'b0, "R8", "no enable from bad dec", en_valid, 0);
  endtask

  task automatic t_bad_fork_create();
    fork_sp_valid = 1; fork_ctx = 0; tick(); idle_in();
    check(err == 1'b1, "R10", "err on bad fork", err, 1);
    repeat (LAT + 1) tick();
    check(ph(0) == 2'd0, "R10", "ctx0 stays free", ph(0), 0);
    create(2, 'hAAAA, 1); tick(); idle_in();
    create(2, 'hBBBB, 0); tick(); idle_in();
    tick(); tick();
    check(en_valid == 1'b0, "R10", "bad create ignored", en_valid, 0);
    post(2); tick(); idle_in();
    tick();
    expect_en("R10", 2, 'hAAAA, 0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_zero_count();
    t_count_down();
    t_same_cycle();
    t_full_and_phases();
    t_bad_release();
    do_reset();
    t_bad_dec();
    do_reset();
    t_bad_fork_create();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule